// File: doc/BRIEF.md
# Banked Interrupt Number Resolver

This block picks the next interrupt to service in a controller whose sources sit in three groups: a small set of basic lines and two banks of 32 lines each. It looks at three pending words. The first is a basic word that carries the basic lines, one summary flag per bank, and a set of copied shortcut flags for selected bank lines. The other two are the raw pending words of the two banks. From these it returns one flat interrupt number, together with a valid flag.

The search follows a fixed order:

1. The basic lines, lowest index first.
2. The bank 1 shortcut flags, in a fixed list order.
3. The bank 2 shortcut flags, in a fixed list order.
4. A lowest-bit scan of each bank word whose summary flag is set. Each scan ignores the bank positions that already have shortcut flags.

The three words are captured on a sample strobe. The answer appears registered on the following clock and holds until the next strobe. Software or a dispatch engine can therefore strobe, read the number, service it, and strobe again.

Top module: `bank_irq_picker`

## Requirements
- R1: The flat numbering is: basic lines are 0 to 7, bank 1 bit k is 8+k, and bank 2 bit k is 40+k.
- R2: If any of basic word bits 7:0 is set, the result is the index of the lowest set bit among them.
- R3: Otherwise, basic word bits 10, 11, 12, 13 and 14 stand for bank 1 bits 7, 9, 10, 18 and 19, and are tried in that order. The first one set gives 8 plus its bank bit. These flags beat every bank 2 source.
- R4: Otherwise, basic word bits 15 to 20 stand for bank 2 bits 21, 22, 23, 24, 25 and 30, and are tried in that order. The first one set gives 40 plus its bank bit.
- R5: Otherwise, if basic word bit 8 (bank 1 summary) is set, the bank 1 word is scanned with bits 7, 9, 10, 18 and 19 forced to zero. Its lowest set bit k gives 8+k.
- R6: Otherwise, if basic word bit 9 (bank 2 summary) is set, the bank 2 word is scanned with bits 21 to 25 and 30 forced to zero. Its lowest set bit k gives 40+k. This also applies when bank 1's summary was set but its masked word was zero.
- R7: When no step finds a source, the valid flag is low. This includes a summary flag set over a masked word of zero, and a bank word with bits set while its summary flag is clear.
- R8: Basic word bits 31:21 have no effect on the result.
- R9: The result is registered. It appears one clock after the edge that sees the sample strobe high, and it holds while the strobe is low, whatever the inputs do.
- R10: The interrupt number output reads zero whenever the valid flag is low.
- R11: After reset, the valid flag and the number are both zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sample_i | input | 1 | Capture strobe for the three pending words |
| basic_i | input | 32 | Basic pending word: lines, summaries, shortcut flags |
| bank1_i | input | 32 | Bank 1 pending word |
| bank2_i | input | 32 | Bank 2 pending word |
| irq_num_o | output | 7 | Flat number of the source to service |
| irq_valid_o | output | 1 | High when irq_num_o names a pending source |

## Verification
The patterns are built so that each one is decided by exactly one search stage.

- Pairs of basic lines check that the lowest index wins.
- Basic lines mixed with shortcut flags show that the basic group beats the shortcuts.
- Pairs of shortcut flags, and mixes across both banks, check the list order and that bank 1 beats bank 2.
- Bank words whose only set bits are shortcut positions tell a masked scan apart from an unmasked one. They also show that control falls through from bank 1 to bank 2.
- Patterns with junk in the ignored upper basic bits, or with the inputs changing between strobes, must leave the result untouched.

// File: rtl/irq_pick_pkg.sv
package irq_pick_pkg;
  localparam int WORD_W  = 32;
  localparam int BASIC_N = 8;
  localparam int SC1_N   = 5;
  localparam int SC2_N   = 6;
  localparam int POS_W   = $clog2(WORD_W);
  // slot 0 holds the highest-priority shortcut position
  localparam logic [SC1_N*POS_W-1:0] SC1_POS = {5'd19, 5'd18, 5'd10, 5'd9, 5'd7};
  localparam logic [SC2_N*POS_W-1:0] SC2_POS = {5'd30, 5'd25, 5'd24, 5'd23, 5'd22, 5'd21};
  localparam int SUM1_BIT = BASIC_N;
  localparam int SUM2_BIT = BASIC_N + 1;
  localparam int SC1_LO   = BASIC_N + 2;
  localparam int SC2_LO   = SC1_LO + SC1_N;
  localparam int USED_W   = SC2_LO + SC2_N;
  localparam int TOTAL_N  = BASIC_N + 2 * WORD_W;
  localparam int NUM_W    = $clog2(TOTAL_N);
  localparam int B1_BASE  = BASIC_N;
  localparam int B2_BASE  = BASIC_N + WORD_W;
endpackage

// File: rtl/lowest_bit_scan.sv
module lowest_bit_scan #(
  parameter int W  = 32,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic          hit,
  output logic [IW-1:0] pos
);
  always_comb begin
    hit = |vec;
    pos = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) pos = IW'(i);
    end
  end
endmodule

// File: rtl/shortcut_pick.sv
module shortcut_pick #(
  parameter int N  = 5,
  parameter int W  = 32,
  parameter int IW = $clog2(W),
  parameter logic [N*IW-1:0] POS = '0
) (
  input  logic [N-1:0]  flags,
  output logic          hit,
  output logic [IW-1:0] bank_pos,
  output logic [W-1:0]  pos_mask
);
  // first set flag in slot order wins
  always_comb begin
    hit      = |flags;
    bank_pos = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (flags[i]) bank_pos = POS[i*IW +: IW];
    end
  end

  // bank positions covered by a shortcut, removed from the full scan
  always_comb begin
    pos_mask = '0;
    for (int i = 0; i < N; i++) begin
      pos_mask[POS[i*IW +: IW]] = 1'b1;
    end
  end
endmodule

// File: rtl/bank_irq_picker.sv
module bank_irq_picker
  import irq_pick_pkg::*;
#(
  parameter int W_WORD = WORD_W,
  parameter int N_NUM  = NUM_W
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic [W_WORD-1:0] basic_i,
  input  logic [W_WORD-1:0] bank1_i,
  input  logic [W_WORD-1:0] bank2_i,
  output logic [N_NUM-1:0]  irq_num_o,
  output logic              irq_valid_o
);
  localparam int PW = $clog2(W_WORD);
  localparam int BW = $clog2(BASIC_N);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  logic unused_hi;
  assign unused_hi = ^basic_i[W_WORD-1:USED_W];

  logic          basic_hit, sc1_hit, sc2_hit, b1_hit, b2_hit;
  logic [BW-1:0] basic_pos;
  logic [PW-1:0] sc1_pos, sc2_pos, b1_pos, b2_pos;
  logic [W_WORD-1:0] mask1, mask2;

  lowest_bit_scan #(.W(BASIC_N), .IW(BW)) u_basic (
    .vec(basic_i[BASIC_N-1:0]), .hit(basic_hit), .pos(basic_pos));

  shortcut_pick #(.N(SC1_N), .W(W_WORD), .IW(PW), .POS(SC1_POS)) u_sc1 (
    .flags(basic_i[SC1_LO +: SC1_N]), .hit(sc1_hit), .bank_pos(sc1_pos), .pos_mask(mask1));

  shortcut_pick #(.N(SC2_N), .W(W_WORD), .IW(PW), .POS(SC2_POS)) u_sc2 (
    .flags(basic_i[SC2_LO +: SC2_N]), .hit(sc2_hit), .bank_pos(sc2_pos), .pos_mask(mask2));

  lowest_bit_scan #(.W(W_WORD), .IW(PW)) u_bank1 (
    .vec(bank1_i & ~mask1), .hit(b1_hit), .pos(b1_pos));

  lowest_bit_scan #(.W(W_WORD), .IW(PW)) u_bank2 (
    .vec(bank2_i & ~mask2), .hit(b2_hit), .pos(b2_pos));

  // next state: fixed search order
  logic [N_NUM-1:0] num_d;
  logic             valid_d;
  always_comb begin
    num_d   = '0;
    valid_d = 1'b1;
    if (basic_hit)                       num_d = N_NUM'(basic_pos);
    else if (sc1_hit)                    num_d = N_NUM'(B1_BASE) + N_NUM'(sc1_pos);
    else if (sc2_hit)                    num_d = N_NUM'(B2_BASE) + N_NUM'(sc2_pos);
    else if (basic_i[SUM1_BIT] && b1_hit) num_d = N_NUM'(B1_BASE) + N_NUM'(b1_pos);
    else if (basic_i[SUM2_BIT] && b2_hit) num_d = N_NUM'(B2_BASE) + N_NUM'(b2_pos);
    else                                 valid_d = 1'b0;
  end

  // registers, enabled by the strobe
  logic [N_NUM-1:0] num_q;
  logic             valid_q;
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      num_q   <= '0;
      valid_q <= 1'b0;
    end else if (sample_i) begin
      num_q   <= num_d;
      valid_q <= valid_d;
    end
  end

  assign irq_num_o   = num_q;
  assign irq_valid_o = valid_q;

  // R9
  hold_between_strobes_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !$past(sample_i) |-> ($stable(irq_num_o) && $stable(irq_valid_o)));

  // R2
  basic_first_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (sample_i && (|basic_i[BASIC_N-1:0])) |=> (irq_valid_o && irq_num_o < N_NUM'(BASIC_N)));

  // R7
  nothing_pending_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (sample_i && basic_i[USED_W-1:0] == '0) |=> !irq_valid_o);

  // R1
  number_range_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    irq_valid_o |-> (irq_num_o < N_NUM'(TOTAL_N)));

  // R10
  zero_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !irq_valid_o |-> (irq_num_o == '0));
endmodule

// File: tb/bank_irq_picker_test.sv
module bank_irq_picker_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sample_i = 1'b0;
  logic [31:0] basic_i = '0, bank1_i = '0, bank2_i = '0;
  logic [6:0]  irq_num_o;
  logic        irq_valid_o;

  int errors = 0;
  int checks = 0;
  logic sample_d = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] last_exp = '0;

  always #5 clk = ~clk;

  bank_irq_picker uut (
    .clk(clk), .rst_ni(rst_ni), .sample_i(sample_i),
    .basic_i(basic_i), .bank1_i(bank1_i), .bank2_i(bank2_i),
    .irq_num_o(irq_num_o), .irq_valid_o(irq_valid_o));

  function automatic logic [7:0] ref_pick(input logic [31:0] b, input logic [31:0] k1,
                                          input logic [31:0] k2);
    int s1[5] = '{7, 9, 10, 18, 19};
    int s2[6] = '{21, 22, 23, 24, 25, 30};
    logic [31:0] m;
    for (int i = 0; i < 8; i++) if (b[i]) return {1'b1, 7'(i)};
    for (int i = 0; i < 5; i++) if (b[10+i]) return {1'b1, 7'(8 + s1[i])};
    for (int i = 0; i < 6; i++) if (b[15+i]) return {1'b1, 7'(40 + s2[i])};
    if (b[8]) begin
      m = k1;
      for (int i = 0; i < 5; i++) m[s1[i]] = 1'b0;
      for (int i = 0; i < 32; i++) if (m[i]) return {1'b1, 7'(8 + i)};
    end
    if (b[9]) begin
      m = k2;
      for (int i = 0; i < 6; i++) m[s2[i]] = 1'b0;
      for (int i = 0; i < 32; i++) if (m[i]) return {1'b1, 7'(40 + i)};
    end
    return 8'h00;
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got valid=%0b num=%0d, expected valid=%0b num=%0d",
               tag, got[7], got[6:0], exp[7], exp[6:0]);
    end
  endtask

  task automatic strobe(input logic [31:0] b, input logic [31:0] k1,
                        input logic [31:0] k2, input string tag);
    @(negedge clk);
    basic_i = b; bank1_i = k1; bank2_i = k2; sample_i = 1'b1;
    last_exp = ref_pick(b, k1, k2);
    exp_q.push_back(last_exp);
    tag_q.push_back(tag);
    @(negedge clk);
    sample_i = 1'b0;
  endtask

  always @(posedge clk) sample_d <= sample_i;

  // monitor: one result per strobe
  always @(negedge clk) begin
    if (sample_d && exp_q.size() > 0) begin
      check(tag_q.pop_front(), {irq_valid_o, irq_num_o}, exp_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 reset state", {irq_valid_o, irq_num_o}, 8'h00);

    strobe(32'h0000_0005, 0, 0, "R2 lowest basic");
    strobe(32'h0000_0080, 0, 0, "R2 basic line 7");
    strobe(32'h0000_0480, 0, 0, "R2 basic beats shortcut");
    strobe(32'h0000_5000, 0, 0, "R3 shortcut order 10 before 19");
    strobe(32'h0000_2800, 0, 0, "R3 shortcut order 9 before 18");
    strobe(32'h0000_C000, 0, 0, "R3 bank1 shortcut beats bank2");
    strobe(32'h0011_0000, 0, 0, "R4 shortcut order 22 before 30");
    strobe(32'h0010_0000, 0, 0, "R4 shortcut for bit 30");
    strobe(32'h0000_0100, 32'h0000_1080, 0, "R5 masked bank1 scan");
    strobe(32'h0000_0100, 32'h8000_0000, 0, "R1 top of bank1");
    strobe(32'h0000_0300, 32'h0000_0080, 32'h0000_0008, "R6 fall through to bank2");
    strobe(32'h0000_0200, 0, 32'h8000_0000, "R1 top of bank2");
    strobe(32'h0000_0200, 0, 32'h4020_0000, "R7 summary over masked zero");
    strobe(32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R7 summary clear");
    strobe(32'h0000_0000, 0, 0, "R10 number zero when idle");
    strobe(32'hFFE0_0000, 0, 0, "R8 upper basic bits ignored");
    strobe(32'h8000_0200, 0, 32'h0000_0001, "R8 upper bits with bank2");

    // R9: change inputs without a strobe, result must hold
    strobe(32'h0000_0020, 0, 0, "R9 load before hold");
    @(negedge clk);
    basic_i = 32'h0000_0001; bank1_i = '1; bank2_i = '1;
    repeat (3) @(negedge clk);
    check("R9 hold without strobe", {irq_valid_o, irq_num_o}, last_exp);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule